// File: doc/BRIEF.md
# Video Pixel Output Formatter

This block sits at the end of a video decoder. For every pixel it takes a luminance byte and a demodulated blue-difference / red-difference chroma pair. A horizontal-valid strobe marks the active pixels. The block drives an 8-bit luminance bus and an 8-bit chroma bus. Chroma can be packed as 4:2:2, where two pixels share one chroma pair and the bus alternates between the two components. It can also be packed as 4:1:1, where four pixels share one pair and the chroma bus carries it two bits of each component at a time.

Static controls do three further things:
- select offset-binary or two's-complement chroma;
- shift either bus one clock earlier or later, independently of the other;
- replace the picture with a fixed blue field while sync is lost.

The block also computes the drive enables for the luminance bus, the chroma bus and the two sync outputs. Several decoders can share one output bus: a daisy-chained priority input and output let a higher-priority decoder take the bus.

Top module: `vid_pix_fmt`

## Requirements
- R1: With `cfg_411`=0, valid pixels form pairs. On the first pixel of a pair `out_c` carries that pixel's Cb, and on the second pixel it carries the first pixel's Cr. `out_y` carries each pixel's own luminance.
- R2: With `cfg_411`=1, valid pixels form groups of four that share the chroma of the group's first pixel. For position k (0..3), `out_c[7:6]` = Cb[7-2k:6-2k], `out_c[5:4]` = Cr[7-2k:6-2k], and `out_c[3:0]` = 0.
- R3: The first valid pixel after `in_hval` rises from 0 to 1 is always position 0, even when the previous group was left incomplete.
- R4: With `cfg_twos`=1, bit 7 of both Cb and Cr is inverted before packing. With 0, chroma is passed through as offset binary.
- R5: With phase code 0, a pixel sampled at rising edge k appears on `out_y`/`out_c` right after edge k+1. `out_hval` follows `in_hval` with that same latency whatever the phase codes.
- R6: Phase code 1 makes a bus show the pixel right after edge k. Code 3 shows it after edge k+2. Code 2 behaves as code 0. `cfg_yphase` and `cfg_cphase` act independently.
- R7: With `cfg_blue_en`=1 and `sync_ok`=0, the sampled pixel is replaced by Y=29, Cb=255, Cr=107 (offset binary, before R4 conversion).
- R8: With `cfg_blue_en`=0, or with `sync_ok`=1, the input video is output unchanged whatever the sync state.
- R9: Each of `y_oe`, `c_oe`, `hs_oe` and `vs_oe` is 1 exactly when its enable bit is 1, `oe_n`=0 and `cas_in_n`=1.
- R10: `cas_out_n` is 0 when `cas_in_n`=0 or `oe_n`=0, and 1 otherwise.
- R11: While `rst_n`=0, `out_y`, `out_c` and `out_hval` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_y | input | 8 | Luminance sample |
| in_cb | input | 8 | Blue-difference sample, offset binary |
| in_cr | input | 8 | Red-difference sample, offset binary |
| in_hval | input | 1 | Horizontal valid strobe |
| sync_ok | input | 1 | Sync is detected |
| cfg_411 | input | 1 | 1 = 4:1:1 packing, 0 = 4:2:2 packing |
| cfg_twos | input | 1 | 1 = two's-complement chroma |
| cfg_blue_en | input | 1 | Enable blue field on sync loss |
| cfg_yphase | input | 2 | Luminance bus phase code |
| cfg_cphase | input | 2 | Chroma bus phase code |
| en_y | input | 1 | Luminance bus enable bit |
| en_c | input | 1 | Chroma bus enable bit |
| en_hs | input | 1 | Horizontal sync output enable bit |
| en_vs | input | 1 | Vertical sync output enable bit |
| oe_n | input | 1 | External output enable, active low |
| cas_in_n | input | 1 | Priority from the higher decoder, active low |
| out_y | output | 8 | Luminance bus |
| out_c | output | 8 | Chroma bus |
| out_hval | output | 1 | Horizontal valid aligned to normal phase |
| y_oe | output | 1 | Drive enable for luminance pads |
| c_oe | output | 1 | Drive enable for chroma pads |
| hs_oe | output | 1 | Drive enable for horizontal sync pad |
| vs_oe | output | 1 | Drive enable for vertical sync pad |
| cas_out_n | output | 1 | Priority to the lower decoder, active low |

## Verification
The bench builds the block with its default 8-bit samples and the default blue constants. With 8-bit samples each 4:1:1 slice is two bits wide, so every slice position and the zeroed low nibble can be seen on the pins. The blue constants differ from all test data, so a missed substitution shows at once. Continuous ramps let a one-clock error in any of the three tap depths show up as a wrong luminance value. Setting Cb equal to Cr on each pixel isolates the pairing of chroma from its component order.

// File: rtl/vof_pkg.sv
package vof_pkg;
  localparam int unsigned PIX_W   = 8;
  localparam int unsigned GRP_W   = 2;
  localparam int unsigned SLICE_W = PIX_W / 4;
  localparam int unsigned N_BUS   = 4;

  typedef enum logic [1:0] {
    PH_NORM = 2'd0,
    PH_FWD  = 2'd1,
    PH_RSV  = 2'd2,
    PH_BACK = 2'd3
  } phase_e;

  // Offset binary <-> two's complement: flip the sign bit.
  function automatic logic [PIX_W-1:0] fmt_chroma(input logic [PIX_W-1:0] v, input logic twos);
    fmt_chroma = {v[PIX_W-1] ^ twos, v[PIX_W-2:0]};
  endfunction

  // Position inside a pixel group: 0..3 for quads, 0..1 for pairs.
  function automatic logic [GRP_W-1:0] step_idx(input logic [GRP_W-1:0] idx, input logic quad);
    if (quad) step_idx = idx + GRP_W'(1);
    else      step_idx = {1'b0, ~idx[0]};
  endfunction

  // Quad packing: slice k of Cb beside slice k of Cr, upper half only.
  function automatic logic [PIX_W-1:0] pack_quad(input logic [PIX_W-1:0] cb,
                                                 input logic [PIX_W-1:0] cr,
                                                 input logic [GRP_W-1:0] k);
    logic [PIX_W-1:0] sb;
    logic [PIX_W-1:0] sr;
    int sh;
    sh = int'(SLICE_W) * (3 - int'(k));
    sb = cb >> sh;
    sr = cr >> sh;
    pack_quad = {sb[SLICE_W-1:0], sr[SLICE_W-1:0], {(PIX_W/2){1'b0}}};
  endfunction

  // Which delay stage a phase code selects; the reserved code acts as normal.
  function automatic logic [1:0] tap_pick(input phase_e p);
    case (p)
      PH_FWD:  tap_pick = 2'd0;
      PH_BACK: tap_pick = 2'd2;
      default: tap_pick = 2'd1;
    endcase
  endfunction
endpackage

// File: rtl/vof_group_ctr.sv
module vof_group_ctr
  import vof_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hval,
  input  logic             quad,
  output logic [GRP_W-1:0] idx
);
  logic             hval_q;
  logic [GRP_W-1:0] idx_q;
  logic             line_start;

  assign line_start = hval & ~hval_q;
  assign idx = line_start ? '0 : (hval ? step_idx(idx_q, quad) : idx_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hval_q <= 1'b0;
      idx_q  <= '0;
    end else begin
      hval_q <= hval;
      if (hval) idx_q <= idx;
    end
  end

  // R3: a rising strobe opens a new group at position 0
  a_r3_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (hval && !hval_q) |=> (idx_q == '0));
endmodule

// File: rtl/vof_chroma_pack.sv
module vof_chroma_pack
  import vof_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hval,
  input  logic             quad,
  input  logic             twos,
  input  logic [GRP_W-1:0] idx,
  input  logic [PIX_W-1:0] cb,
  input  logic [PIX_W-1:0] cr,
  output logic [PIX_W-1:0] c_word
);
  logic [PIX_W-1:0] cb_f, cr_f;
  logic [PIX_W-1:0] lat_cb, lat_cr;
  logic [PIX_W-1:0] cb_g, cr_g;
  logic             head;

  assign cb_f = fmt_chroma(cb, twos);
  assign cr_f = fmt_chroma(cr, twos);
  assign head = (idx == '0);
  assign cb_g = head ? cb_f : lat_cb;
  assign cr_g = head ? cr_f : lat_cr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_cb <= '0;
      lat_cr <= '0;
    end else if (hval && head) begin
      lat_cb <= cb_f;
      lat_cr <= cr_f;
    end
  end

  always_comb begin
    if (quad) c_word = pack_quad(cb_g, cr_g, idx);
    else      c_word = idx[0] ? cr_g : cb_g;
  end

  // R1: second pixel of a pair carries the Cr captured at the pair head
  a_r1_cr_from_head: assert property (@(posedge clk) disable iff (!rst_n)
    (hval && !quad && idx == GRP_W'(1) && $past(hval && !quad && idx == '0))
      |-> (c_word == $past(cr_f)));
endmodule

// File: rtl/vof_phase_tap.sv
module vof_phase_tap
  import vof_pkg::*;
#(
  parameter int unsigned W = PIX_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  input  logic [1:0]   phase,
  output logic [W-1:0] q
);
  localparam int unsigned DEPTH = 3;
  logic [DEPTH-1:0][W-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg <= '0;
    else        stg <= {stg[DEPTH-2:0], d};
  end

  assign q = stg[tap_pick(phase_e'(phase))];

  // R6: moving from normal to backward replays the previous normal value
  a_r6_back_after_norm: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_BACK && $past(phase) == PH_NORM) |-> (q == $past(q)));
  // R6: moving from forward to normal replays the previous forward value
  a_r6_norm_after_fwd: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_NORM && $past(phase) == PH_FWD) |-> (q == $past(q)));
endmodule

// File: rtl/vof_oe_ctl.sv
module vof_oe_ctl
  import vof_pkg::*;
#(
  parameter int unsigned NB = N_BUS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NB-1:0] bus_en,
  input  logic          oe_n,
  input  logic          cas_in_n,
  output logic [NB-1:0] bus_oe,
  output logic          cas_out_n
);
  logic grant;

  assign grant = ~oe_n & cas_in_n;
  for (genvar b = 0; b < NB; b++) begin : g_bus
    assign bus_oe[b] = grant & bus_en[b];
  end
  assign cas_out_n = cas_in_n & oe_n;

  // R10: a higher-priority decoder silences every bus and is passed on
  a_r10_yield: assert property (@(posedge clk) disable iff (!rst_n)
    !cas_in_n |-> (bus_oe == '0 && !cas_out_n));
  // R9: without the external enable no bus is driven
  a_r9_pin_gate: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> (bus_oe == '0));
  // R10: an enabled unit claims the chain
  a_r10_claim: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> !cas_out_n);
endmodule

// File: rtl/vid_pix_fmt.sv
module vid_pix_fmt
  import vof_pkg::*;
#(
  parameter int unsigned   W       = PIX_W,
  parameter logic [W-1:0]  BLUE_Y  = 29,
  parameter logic [W-1:0]  BLUE_CB = 255,
  parameter logic [W-1:0]  BLUE_CR = 107
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] in_y,
  input  logic [W-1:0] in_cb,
  input  logic [W-1:0] in_cr,
  input  logic         in_hval,
  input  logic         sync_ok,
  input  logic         cfg_411,
  input  logic         cfg_twos,
  input  logic         cfg_blue_en,
  input  logic [1:0]   cfg_yphase,
  input  logic [1:0]   cfg_cphase,
  input  logic         en_y,
  input  logic         en_c,
  input  logic         en_hs,
  input  logic         en_vs,
  input  logic         oe_n,
  input  logic         cas_in_n,
  output logic [W-1:0] out_y,
  output logic [W-1:0] out_c,
  output logic         out_hval,
  output logic         y_oe,
  output logic         c_oe,
  output logic         hs_oe,
  output logic         vs_oe,
  output logic         cas_out_n
);
  localparam int unsigned HV_LAT = 2;

  logic             blue_now;
  logic [W-1:0]     src_y, src_cb, src_cr;
  logic [GRP_W-1:0] grp_idx;
  logic [W-1:0]     c_word;
  logic [HV_LAT-1:0] hv_pipe;
  logic [N_BUS-1:0] bus_oe;

  assign blue_now = cfg_blue_en & ~sync_ok;
  assign src_y  = blue_now ? BLUE_Y  : in_y;
  assign src_cb = blue_now ? BLUE_CB : in_cb;
  assign src_cr = blue_now ? BLUE_CR : in_cr;

  vof_group_ctr u_grp (
    .clk(clk), .rst_n(rst_n), .hval(in_hval), .quad(cfg_411), .idx(grp_idx)
  );

  vof_chroma_pack u_pack (
    .clk(clk), .rst_n(rst_n), .hval(in_hval), .quad(cfg_411), .twos(cfg_twos),
    .idx(grp_idx), .cb(src_cb), .cr(src_cr), .c_word(c_word)
  );

  vof_phase_tap #(.W(W)) u_ytap (
    .clk(clk), .rst_n(rst_n), .d(src_y), .phase(cfg_yphase), .q(out_y)
  );

  vof_phase_tap #(.W(W)) u_ctap (
    .clk(clk), .rst_n(rst_n), .d(c_word), .phase(cfg_cphase), .q(out_c)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hv_pipe <= '0;
    else        hv_pipe <= {hv_pipe[HV_LAT-2:0], in_hval};
  end
  assign out_hval = hv_pipe[HV_LAT-1];

  vof_oe_ctl #(.NB(N_BUS)) u_oe (
    .clk(clk), .rst_n(rst_n), .bus_en({en_vs, en_hs, en_c, en_y}),
    .oe_n(oe_n), .cas_in_n(cas_in_n), .bus_oe(bus_oe), .cas_out_n(cas_out_n)
  );
  assign y_oe  = bus_oe[0];
  assign c_oe  = bus_oe[1];
  assign hs_oe = bus_oe[2];
  assign vs_oe = bus_oe[3];

  // R7: blue field reaches the forward-tapped luminance one edge later
  a_r7_blue_fwd: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_yphase == PH_FWD && $past(cfg_blue_en && !sync_ok)) |-> (out_y == BLUE_Y));
  // R2: quad packing leaves the lower half of the chroma bus at zero
  a_r2_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_cphase == PH_FWD && $past(cfg_411)) |-> (out_c[W/2-1:0] == '0));
endmodule

// File: tb/vid_pix_fmt_tb_top.sv
`timescale 1ns/1ps
module vid_pix_fmt_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] in_y = '0, in_cb = '0, in_cr = '0;
  logic       in_hval = 1'b0, sync_ok = 1'b1;
  logic       cfg_411 = 1'b0, cfg_twos = 1'b0, cfg_blue_en = 1'b1;
  logic [1:0] cfg_yphase = 2'd0, cfg_cphase = 2'd0;
  logic       en_y = 1'b1, en_c = 1'b1, en_hs = 1'b1, en_vs = 1'b1;
  logic       oe_n = 1'b0, cas_in_n = 1'b1;
  logic [7:0] out_y, out_c;
  logic       out_hval, y_oe, c_oe, hs_oe, vs_oe, cas_out_n;

  always #2 clk = ~clk;

  vid_pix_fmt dut_i (
    .clk(clk), .rst_n(rst_n), .in_y(in_y), .in_cb(in_cb), .in_cr(in_cr),
    .in_hval(in_hval), .sync_ok(sync_ok), .cfg_411(cfg_411), .cfg_twos(cfg_twos),
    .cfg_blue_en(cfg_blue_en), .cfg_yphase(cfg_yphase), .cfg_cphase(cfg_cphase),
    .en_y(en_y), .en_c(en_c), .en_hs(en_hs), .en_vs(en_vs), .oe_n(oe_n),
    .cas_in_n(cas_in_n), .out_y(out_y), .out_c(out_c), .out_hval(out_hval),
    .y_oe(y_oe), .c_oe(c_oe), .hs_oe(hs_oe), .vs_oe(vs_oe), .cas_out_n(cas_out_n)
  );

  int  n_chk = 0, n_bad = 0;
  bit  done = 1'b0;

  // {mark_restart, brk, quad, twos, y, cb, cr, exp_y, exp_c}
  localparam int NV = 20;
  localparam logic [43:0] VEC [NV] = '{
    {1'b0,1'b1,1'b0,1'b0, 8'h10,8'h40,8'hC0, 8'h10,8'h40},
    {1'b0,1'b0,1'b0,1'b0, 8'h11,8'h99,8'h77, 8'h11,8'hC0},
    {1'b0,1'b0,1'b0,1'b0, 8'h12,8'h50,8'hA0, 8'h12,8'h50},
    {1'b0,1'b0,1'b0,1'b0, 8'h13,8'h00,8'h33, 8'h13,8'hA0},
    {1'b0,1'b1,1'b0,1'b1, 8'h20,8'h80,8'h7F, 8'h20,8'h00},
    {1'b0,1'b0,1'b0,1'b1, 8'h21,8'h00,8'h00, 8'h21,8'hFF},
    {1'b0,1'b0,1'b0,1'b1, 8'h30,8'h12,8'h34, 8'h30,8'h92},
    {1'b1,1'b1,1'b0,1'b1, 8'h31,8'h56,8'h78, 8'h31,8'hD6},
    {1'b0,1'b1,1'b1,1'b0, 8'h40,8'hE4,8'h1B, 8'h40,8'hC0},
    {1'b0,1'b0,1'b1,1'b0, 8'h41,8'hFF,8'hFF, 8'h41,8'h90},
    {1'b0,1'b0,1'b1,1'b0, 8'h42,8'hFF,8'hFF, 8'h42,8'h60},
    {1'b0,1'b0,1'b1,1'b0, 8'h43,8'hFF,8'hFF, 8'h43,8'h30},
    {1'b0,1'b0,1'b1,1'b0, 8'h44,8'h0F,8'hF0, 8'h44,8'h30},
    {1'b0,1'b1,1'b1,1'b1, 8'h50,8'h00,8'hFF, 8'h50,8'h90},
    {1'b0,1'b0,1'b1,1'b1, 8'h51,8'hAA,8'hAA, 8'h51,8'h30},
    {1'b0,1'b0,1'b1,1'b1, 8'h52,8'hAA,8'hAA, 8'h52,8'h30},
    {1'b0,1'b0,1'b1,1'b1, 8'h53,8'hAA,8'hAA, 8'h53,8'h30},
    {1'b0,1'b1,1'b1,1'b0, 8'h60,8'hE4,8'h1B, 8'h60,8'hC0},
    {1'b0,1'b0,1'b1,1'b0, 8'h61,8'h00,8'h00, 8'h61,8'h90},
    {1'b1,1'b1,1'b1,1'b0, 8'h62,8'h1B,8'hE4, 8'h62,8'h30}
  };

  // Expected-value ring, indexed by drive step.
  logic       r_v [8];
  logic [7:0] r_y [8], r_c [8];
  logic       r_h [8];
  string      r_t [8];
  int         st = 0;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic int lat_of(input logic [1:0] p);
    if (p == 2'd1)      return 1;
    else if (p == 2'd3) return 3;
    else                return 2;
  endfunction

  task automatic step(input logic hv, input logic [7:0] y, input logic [7:0] cb,
                      input logic [7:0] cr, input logic v, input logic [7:0] ey,
                      input logic [7:0] ec, input string tag);
    int dy, dc;
    @(negedge clk);
    dy = lat_of(cfg_yphase);
    dc = lat_of(cfg_cphase);
    if (st >= dy && r_v[(st-dy)%8])
      chk((cfg_yphase == 2'd0) ? {r_t[(st-dy)%8], " Y"} : {"R6 Y ", r_t[(st-dy)%8]},
          out_y, r_y[(st-dy)%8]);
    if (st >= dc && r_v[(st-dc)%8])
      chk((cfg_cphase == 2'd0) ? {r_t[(st-dc)%8], " C"} : {"R6 C ", r_t[(st-dc)%8]},
          out_c, r_c[(st-dc)%8]);
    if (st >= 2) chk("R5 hval", {7'd0, out_hval}, {7'd0, r_h[(st-2)%8]});
    in_hval = hv; in_y = y; in_cb = cb; in_cr = cr;
    r_v[st%8] = v; r_y[st%8] = ey; r_c[st%8] = ec; r_h[st%8] = hv; r_t[st%8] = tag;
    st++;
  endtask

  task automatic gap();
    step(1'b0, 8'h00, 8'h00, 8'h00, 1'b0, 8'h00, 8'h00, "");
  endtask

  task automatic oe_chk(input string tag, input logic [4:0] exp);
    #1;
    chk(tag, {3'd0, y_oe, c_oe, hs_oe, vs_oe, cas_out_n}, {3'd0, exp});
  endtask

  initial begin
    for (int i = 0; i < 8; i++) begin r_v[i] = 1'b0; r_h[i] = 1'b0; end
    // R11: outputs held at zero during reset
    repeat (3) @(negedge clk);
    in_y = 8'hAB; in_cb = 8'hCD; in_cr = 8'hEF; in_hval = 1'b1;
    repeat (3) @(negedge clk);
    chk("R11 reset out_y", out_y, 8'h00);
    chk("R11 reset out_c", out_c, 8'h00);
    chk("R11 reset out_hval", {7'd0, out_hval}, 8'h00);
    in_hval = 1'b0;
    rst_n = 1'b1;

    // Table walk: packing, conversion and restart (R1 R2 R3 R4, latency R5)
    for (int i = 0; i < NV; i++) begin
      logic [43:0] r;
      string tg;
      r = VEC[i];
      if (r[42]) begin
        gap();
        cfg_411 = r[41];
        cfg_twos = r[40];
      end
      tg = r[41] ? "R2" : "R1";
      if (r[40]) tg = {tg, " R4"};
      if (r[43]) tg = {tg, " R3"};
      tg = $sformatf("%s row%0d", tg, i);
      step(1'b1, r[39:32], r[31:24], r[23:16], 1'b1, r[15:8], r[7:0], tg);
    end
    repeat (4) gap();

    // R7: blue field on sync loss, offset then two's complement
    cfg_411 = 1'b0; cfg_twos = 1'b0; sync_ok = 1'b0; cfg_blue_en = 1'b1;
    step(1'b1, 8'h55, 8'h11, 8'h22, 1'b1, 8'h1D, 8'hFF, "R7 blue p0");
    step(1'b1, 8'h56, 8'h33, 8'h44, 1'b1, 8'h1D, 8'h6B, "R7 blue p1");
    gap();
    cfg_twos = 1'b1;
    step(1'b1, 8'h57, 8'h11, 8'h22, 1'b1, 8'h1D, 8'h7F, "R7 R4 blue p0");
    step(1'b1, 8'h58, 8'h33, 8'h44, 1'b1, 8'h1D, 8'hEB, "R7 R4 blue p1");
    gap();
    // R8: blue disabled passes video while sync is lost
    cfg_twos = 1'b0; cfg_blue_en = 1'b0;
    step(1'b1, 8'h77, 8'h12, 8'h34, 1'b1, 8'h77, 8'h12, "R8 p0");
    step(1'b1, 8'h78, 8'h56, 8'h9A, 1'b1, 8'h78, 8'h34, "R8 p1");
    gap();
    sync_ok = 1'b1; cfg_blue_en = 1'b1;
    repeat (3) gap();

    // R6: phase codes on a ramp, Y and C moved independently
    for (int i = 0; i < 12; i++) begin
      logic [7:0] v;
      v = 8'h80 + 8'(i);
      if (i == 4)  begin cfg_yphase = 2'd1; cfg_cphase = 2'd3; end
      if (i == 6)  begin cfg_yphase = 2'd3; cfg_cphase = 2'd1; end
      if (i == 8)  begin cfg_yphase = 2'd2; cfg_cphase = 2'd2; end
      if (i == 10) begin cfg_yphase = 2'd0; cfg_cphase = 2'd0; end
      step(1'b1, v, v, v, 1'b1, v, (i % 2 == 0) ? v : v - 8'd1,
           $sformatf("R5 ramp%0d", i));
    end
    repeat (4) gap();

    // R9 / R10: output enables and priority chain
    en_y = 1'b1; en_c = 1'b1; en_hs = 1'b1; en_vs = 1'b1; oe_n = 1'b0; cas_in_n = 1'b1;
    oe_chk("R9 all on", 5'b11110);
    en_c = 1'b0;
    oe_chk("R9 C bit off", 5'b10110);
    en_c = 1'b1; en_vs = 1'b0;
    oe_chk("R9 VS bit off", 5'b11100);
    en_vs = 1'b1; oe_n = 1'b1;
    oe_chk("R9 R10 pin off", 5'b00001);
    oe_n = 1'b0; cas_in_n = 1'b0;
    oe_chk("R10 yield enabled", 5'b00000);
    oe_n = 1'b1;
    oe_chk("R10 pass chain", 5'b00000);
    cas_in_n = 1'b1; oe_n = 1'b0;
    oe_chk("R10 claim", 5'b11110);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule